// File: doc/BRIEF.md
# Valley-Lockout Switching Mode Selector

This block decides when the power switch of a quasi-resonant flyback controller turns on again after each off-time. A digitized feedback level in millivolts picks one of five modes: turn-on at the first, second, third or fourth valley of the drain ringing, or a foldback mode in which an external period timer sets the switching frequency. The mode changes use separate falling and rising feedback thresholds. This hysteresis keeps the controller locked on one valley until the load changes by a clear margin.

After the driver turns off, the block ignores the valley-detect input for a blanking interval, so that leakage ringing is not counted. It then counts falling edges of that input, and it issues a one-cycle turn-on request when the count reaches the selected valley. When the ringing is too damped to produce an edge, a timeout stands in for the missing valley. This timeout is longer while soft-start is still running. All intervals are parameters in clock cycles.

Top module: `valley_mode_sel`

## Requirements
- R1: While `rst_n` is low, `mode` reads 1 and `turn_on_req` reads 0. The mode first moves during the first switching cycle after reset.
- R2: The encoding of `mode` is 1, 2, 3 or 4 for the valley of that number and 0 for foldback. With falling feedback, a mode steps down one valley when `fb_mv` is below its threshold: 1400 for 1 to 2, 1200 for 2 to 3, 900 for 3 to 4, and 800 for 4 to foldback.
- R3: With rising feedback, a mode steps up when `fb_mv` is at or above its threshold: 1400 for foldback to 4, 1600 for 4 to 3, 1800 for 3 to 2, and 2000 for 2 to 1. Between the two thresholds of the current mode, the mode holds.
- R4: The mode changes by at most one step per clock. It changes only while `drv_on` is low and either blanking is running or the request of that off-time has already been issued. It never changes while the driver is on or while valleys are being counted.
- R5: After each turn-off, every qualified falling edge of `valley_in` adds one to the valley count. In a valley mode, `turn_on_req` goes high for one cycle just after the clock edge at which the count reaches `mode`.
- R6: Edges of `valley_in` seen at the first `BLANK_CYC` rising clock edges with `drv_on` low after an on-time are ignored. An edge at the next clock edge counts.
- R7: With `ss_done` high, `TMO_RUN_CYC` counting clock edges without a qualified valley produce a substitute valley. The timeout restarts after every real or substitute valley.
- R8: While `ss_done` is low, the substitute valley timeout is `TMO_SS_CYC` clock edges instead.
- R9: In foldback mode (0), valleys and timeouts never request turn-on. A high `vco_period_end` at a clock edge with `drv_on` low requests turn-on one cycle later.
- R10: At most one request is issued per off-time, and none is issued while the driver is on. The valley count restarts from zero at every on-time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| fb_mv | input | FB_W | Feedback level in millivolts |
| valley_in | input | 1 | Valley detector output; a falling edge marks a valley |
| drv_on | input | 1 | High while the power switch is driven on |
| ss_done | input | 1 | High once soft-start has finished |
| vco_period_end | input | 1 | Period-end pulse from the external foldback timer |
| turn_on_req | output | 1 | One-cycle request to turn the switch on |
| mode | output | 3 | Current mode: 1 to 4 valley number, 0 foldback |

## Verification
The assertions check on every cycle that the mode stays legal and moves by one step at most, that it is frozen while the driver is on, and that requests are single pulses. They also check that no request appears during an on-time, and none in foldback mode without a period-end pulse. The exact threshold values, the hysteresis holds, the blanking boundary, the two timeout lengths and the restart of the count are shown only by the bench's scenarios. The bench sweeps the feedback up and down across every threshold, and it measures in cycles when the request appears.

// File: rtl/valley_mode_sel.sv
`timescale 1ns/1ps
module valley_mode_sel #(
  parameter int FB_W        = 12,
  parameter int BLANK_CYC   = 12,
  parameter int TMO_RUN_CYC = 24,
  parameter int TMO_SS_CYC  = 160,
  parameter int FALL_1_2    = 1400,
  parameter int FALL_2_3    = 1200,
  parameter int FALL_3_4    = 900,
  parameter int FALL_4_V    = 800,
  parameter int RISE_V_4    = 1400,
  parameter int RISE_4_3    = 1600,
  parameter int RISE_3_2    = 1800,
  parameter int RISE_2_1    = 2000
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [FB_W-1:0] fb_mv,
  input  logic            valley_in,
  input  logic            drv_on,
  input  logic            ss_done,
  input  logic            vco_period_end,
  output logic            turn_on_req,
  output logic [2:0]      mode
);
  localparam int TMAX = (TMO_SS_CYC > TMO_RUN_CYC) ? TMO_SS_CYC : TMO_RUN_CYC;
  localparam int TW   = $clog2(TMAX + 1);
  localparam int BW   = $clog2(BLANK_CYC + 1);
  localparam logic [2:0] M_VCO = 3'd0;

  logic [2:0]    mode_q, mode_d, vcnt_q;
  logic [BW-1:0] blank_q;
  logic [TW-1:0] tmo_q;
  logic          valley_q, fired_q, req_q;

  wire blanking  = blank_q != '0;
  wire armed     = !drv_on && !blanking && !fired_q;
  wire counting  = armed && mode_q != M_VCO;
  wire valley_fall = valley_q && !valley_in;
  wire [TW-1:0] tmo_lim = ss_done ? TW'(TMO_RUN_CYC) : TW'(TMO_SS_CYC);
  wire [TW-1:0] tmo_nx  = tmo_q + TW'(1);
  wire tmo_hit   = counting && tmo_nx >= tmo_lim;
  wire step      = counting && (valley_fall || tmo_hit);
  wire [2:0] vcnt_nx = vcnt_q + 3'd1;
  wire valley_hit = step && vcnt_nx == mode_q;
  wire vco_hit   = !drv_on && !fired_q && mode_q == M_VCO && vco_period_end;
  wire req_d     = valley_hit || vco_hit;
  wire mode_upd  = !drv_on && (blanking || fired_q);

  always_comb begin
    mode_d = mode_q;
    case (mode_q)
      3'd1: if (fb_mv < FB_W'(FALL_1_2)) mode_d = 3'd2;
      3'd2: if (fb_mv < FB_W'(FALL_2_3)) mode_d = 3'd3;
            else if (fb_mv >= FB_W'(RISE_2_1)) mode_d = 3'd1;
      3'd3: if (fb_mv < FB_W'(FALL_3_4)) mode_d = 3'd4;
            else if (fb_mv >= FB_W'(RISE_3_2)) mode_d = 3'd2;
      3'd4: if (fb_mv < FB_W'(FALL_4_V)) mode_d = M_VCO;
            else if (fb_mv >= FB_W'(RISE_4_3)) mode_d = 3'd3;
      M_VCO: if (fb_mv >= FB_W'(RISE_V_4)) mode_d = 3'd4;
      default: mode_d = 3'd1;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q   <= 3'd1;
      vcnt_q   <= 3'd0;
      blank_q  <= '0;
      tmo_q    <= '0;
      valley_q <= 1'b0;
      fired_q  <= 1'b0;
      req_q    <= 1'b0;
    end else begin
      valley_q <= valley_in;
      if (drv_on) blank_q <= BW'(BLANK_CYC);
      else if (blanking) blank_q <= blank_q - BW'(1);
      tmo_q    <= (!counting || step) ? '0 : tmo_nx;
      if (drv_on) vcnt_q <= 3'd0;
      else if (step) vcnt_q <= vcnt_nx;
      fired_q  <= drv_on ? 1'b0 : (fired_q || req_d);
      req_q    <= req_d;
      if (mode_upd) mode_q <= mode_d;
    end
  end

  assign turn_on_req = req_q;
  assign mode        = mode_q;
endmodule

// File: rtl/valley_mode_sel_chk.sv
`timescale 1ns/1ps
module valley_mode_sel_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       drv_on,
  input logic       vco_period_end,
  input logic       turn_on_req,
  input logic [2:0] mode
);
  // R2
  mode_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mode <= 3'd4);

  // R4
  mode_hold_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
    drv_on |=> $stable(mode));

  // R4
  mode_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(mode) |-> (mode == $past(mode) + 3'd1) || (mode == $past(mode) - 3'd1)
                       || (mode == 3'd0 && $past(mode) == 3'd4)
                       || (mode == 3'd4 && $past(mode) == 3'd0));

  // R10
  req_off_while_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
    drv_on |=> !turn_on_req);

  // R10
  single_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    turn_on_req |=> !turn_on_req);

  // R9
  vco_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 3'd0 && !vco_period_end) |=> !turn_on_req);
endmodule

bind valley_mode_sel valley_mode_sel_chk i_chk (
  .clk(clk), .rst_n(rst_n), .drv_on(drv_on), .vco_period_end(vco_period_end),
  .turn_on_req(turn_on_req), .mode(mode)
);

// File: tb/test_valley_mode_sel.sv
`timescale 1ns/1ps
module test_valley_mode_sel;
  localparam int BLANK = 12;
  localparam int TRUN  = 24;
  localparam int TSS   = 160;
  localparam int NV    = 20;
  localparam int VEC_FB [NV] = '{2000, 1400, 1399, 1200, 1199, 1500, 900, 899, 800, 799,
                                 1399, 1400, 1599, 1600, 1799, 1800, 1999, 2000, 500, 2500};
  localparam int VEC_MD [NV] = '{1, 1, 2, 2, 3, 3, 3, 4, 4, 0,
                                 0, 4, 4, 3, 3, 2, 2, 1, 0, 1};

  logic clk = 0, rst_n = 0;
  logic [11:0] fb_mv = 12'd2500;
  logic valley_in = 1, drv_on = 0, ss_done = 1, vco_period_end = 0;
  logic turn_on_req;
  logic [2:0] mode;
  int checks = 0, errors = 0;
  bit done = 0;

  valley_mode_sel #(.BLANK_CYC(BLANK), .TMO_RUN_CYC(TRUN), .TMO_SS_CYC(TSS)) i_valley_mode_sel (
    .clk(clk), .rst_n(rst_n), .fb_mv(fb_mv), .valley_in(valley_in), .drv_on(drv_on),
    .ss_done(ss_done), .vco_period_end(vco_period_end), .turn_on_req(turn_on_req), .mode(mode));

  always #2 clk = ~clk;

  task automatic chk(input string tag, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s got %0d expected %0d", tag, got, exp);
    end
  endtask

  task automatic drv_off_wait(input int n);
    drv_on = 1;
    @(negedge clk);
    drv_on = 0;
    repeat (n) @(negedge clk);
  endtask

  task automatic valley_pulse(output int r);
    valley_in = 0;
    @(negedge clk);
    r = int'(turn_on_req);
    valley_in = 1;
    @(negedge clk);
  endtask

  task automatic vco_pulse(output int r);
    vco_period_end = 1;
    @(negedge clk);
    r = int'(turn_on_req);
    vco_period_end = 0;
    @(negedge clk);
  endtask

  task automatic cycles_to_req(input int lim, output int n);
    n = 0;
    for (int i = 1; i <= lim && n == 0; i++) begin
      @(negedge clk);
      if (turn_on_req) n = i;
    end
  endtask

  initial begin
    repeat (20000 * 10) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog got 0 expected 1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int r, n;
    repeat (3) @(negedge clk);
    chk("R1 reset mode", mode, 1);
    chk("R1 reset req", turn_on_req, 0);
    rst_n = 1;
    @(negedge clk);

    for (int v = 0; v < NV; v++) begin
      fb_mv = 12'(VEC_FB[v]);
      drv_off_wait(BLANK);
      chk($sformatf("R2 R3 mode at fb %0d", VEC_FB[v]), mode, VEC_MD[v]);
      if (VEC_MD[v] != 0) begin
        for (int p = 1; p <= VEC_MD[v]; p++) begin
          valley_pulse(r);
          chk($sformatf("R5 valley %0d of %0d", p, VEC_MD[v]), r, (p == VEC_MD[v]) ? 1 : 0);
        end
      end else begin
        for (int p = 0; p < 3; p++) begin
          valley_pulse(r);
          chk("R9 valley in foldback", r, 0);
        end
        vco_pulse(r);
        chk("R9 period end request", r, 1);
      end
    end

    // R6 blanking boundary, mode 1
    drv_off_wait(BLANK - 1);
    valley_pulse(r);
    chk("R6 edge at last blanked clock", r, 0);
    valley_pulse(r);
    chk("R6 edge after blanking", r, 1);
    drv_off_wait(BLANK);
    valley_pulse(r);
    chk("R6 first qualified edge", r, 1);

    // R10 single request, none while on, count restart
    valley_pulse(r);
    chk("R10 second request blocked", r, 0);
    drv_on = 1;
    valley_pulse(r);
    chk("R10 no request while on", r, 0);
    fb_mv = 12'd1000;
    drv_off_wait(BLANK);
    chk("R2 mode 3 at 1000", mode, 3);
    valley_pulse(r);
    valley_pulse(r);
    chk("R5 two valleys in mode 3", r, 0);
    drv_off_wait(BLANK);
    valley_pulse(r);
    valley_pulse(r);
    chk("R10 count restarted", r, 0);
    valley_pulse(r);
    chk("R10 third valley after restart", r, 1);

    // R7 timeout, mode 3
    drv_off_wait(BLANK);
    cycles_to_req(400, n);
    chk("R7 three timeouts", n, 3 * TRUN);
    drv_off_wait(BLANK);
    valley_pulse(r);
    cycles_to_req(400, n);
    chk("R7 valley then two timeouts", n, 2 * TRUN - 1);

    // R8 soft-start timeout, mode 1
    fb_mv = 12'd2500;
    ss_done = 0;
    drv_off_wait(BLANK);
    chk("R3 back to mode 1", mode, 1);
    cycles_to_req(400, n);
    chk("R8 soft-start timeout", n, TSS);
    ss_done = 1;
    drv_off_wait(BLANK);
    cycles_to_req(400, n);
    chk("R7 run timeout", n, TRUN);

    // R4 freeze while counting, one step per clock
    drv_off_wait(BLANK);
    fb_mv = 12'd500;
    repeat (3) @(negedge clk);
    chk("R4 frozen while counting", mode, 1);
    valley_pulse(r);
    chk("R4 target kept", r, 1);
    chk("R4 step 1", mode, 2);
    @(negedge clk);
    chk("R4 step 2", mode, 3);
    @(negedge clk);
    chk("R4 step 3", mode, 4);
    @(negedge clk);
    chk("R4 step 4", mode, 0);
    fb_mv = 12'd2500;
    drv_on = 1;
    repeat (5) @(negedge clk);
    chk("R4 held while on", mode, 0);
    drv_on = 0;
    @(negedge clk);
    chk("R4 first blanking step", mode, 4);
    repeat (BLANK) @(negedge clk);

    // R9 foldback ignores timeout and waits for period end
    fb_mv = 12'd500;
    drv_off_wait(BLANK);
    chk("R2 foldback at 500", mode, 0);
    cycles_to_req(200, n);
    chk("R9 no timeout request", n, 0);
    vco_pulse(r);
    chk("R9 period end request", r, 1);
    vco_pulse(r);
    chk("R10 one request per off-time", r, 0);
    drv_on = 1;
    vco_pulse(r);
    chk("R9 period end while on", r, 0);
    drv_on = 0;

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule